// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block decides which of up to N local interrupt units should receive an interrupt message. A request carries an 8-bit destination byte, a physical/logical mode bit, a 2-bit shorthand code, the 8-bit index of the sending unit and a 3-bit delivery mode. Each unit supplies three things: a present bit, an 8-bit logical ID and a 4-bit logical model. The model value 4'hF means flat and 4'h0 means cluster.

The shorthand can override the destination field. In physical mode the destination byte is compared against unit indices, and 8'hFF addresses every unit. In logical mode each unit matches according to its own model. Units that are not present are removed from every result. When the delivery mode asks for lowest priority, the set is narrowed to its lowest-indexed member. The result is registered in the cycle after the request strobe and is held until the next request.

Top module: `irq_dest_resolver`

## Requirements
- R1: While reset is asserted and after its release, `tgt_mask` is all zeros and `tgt_valid` is low until the first request.
- R2: A request sampled at a rising edge updates `tgt_mask` at that edge, and `tgt_valid` is high for exactly that following cycle. Without a request, `tgt_mask` keeps its value.
- R3: Shorthand code 0 uses the destination field. Code 1 selects only the unit whose index equals `req_src_id`. Code 2 selects every unit. Code 3 selects every unit except the sender.
- R4: With shorthand 0 and mode bit 0 (physical), a destination of 8'hFF selects all units. Any other destination selects only the unit with that index, and none if the index is N or more.
- R5: With shorthand 0 and mode bit 1 (logical), a unit whose model is 4'hF is selected when the destination AND its logical ID is nonzero.
- R6: In logical mode, a unit whose model is 4'h0 is selected when bits [7:4] of destination and logical ID are equal and the AND of bits [3:0] of both is nonzero.
- R7: In logical mode, a unit whose model is any value other than 4'hF or 4'h0 is never selected.
- R8: A unit whose present bit was low at the request is cleared in the result for every shorthand and mode, broadcasts included.
- R9: Delivery mode 3'd1 (lowest priority) keeps only the lowest-indexed selected unit. Every other delivery code (0 fixed, 5 init, 6 startup, 7 external, and the rest) keeps the full set.
- R10: For shorthand codes 1 to 3, the destination byte and the mode bit have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | Shorthand override code |
| req_src_id | input | 8 | Index of sending unit |
| req_dmode | input | 3 | Delivery mode code |
| unit_present | input | N | Per-unit present bits |
| unit_log_id | input | 8*N | Per-unit logical IDs, unit i at [8i+7:8i] |
| unit_model | input | 4*N | Per-unit logical model, unit i at [4i+3:4i] |
| tgt_mask | output | N | Registered selection mask |
| tgt_valid | output | 1 | High one cycle after a request |

## Verification
All 256 destination bytes are swept in both addressing modes over three unit configurations: mixed models including invalid ones, all flat, and all cluster. This separates flat AND-matching from cluster nibble matching and shows that invalid models never match. Each configuration is repeated with all units present and with a sparse present pattern, so presence masking is seen separately from matching. Every shorthand is tried with every sender index, including indices beyond N, and with varying destinations, which shows that the field is ignored. All eight delivery codes are also tried, so lowest-priority reduction is distinguished from pass-through.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    localparam logic [7:0] BCAST_DEST    = 8'hFF;
    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

endpackage

// File: rtl/irq_unit_match.sv
module irq_unit_match
    import irq_res_pkg::*;
#(
    parameter int UNIT_IDX = 0
) (
    input  logic [7:0] dest,
    input  logic       logical,
    input  logic [1:0] shorthand,
    input  logic [7:0] src_id,
    input  logic [7:0] log_id,
    input  logic [3:0] model,
    input  logic       present,
    output logic       hit
);
    localparam logic [7:0] MY_IDX = 8'(UNIT_IDX);

    logic phys_hit, flat_hit, clus_hit, field_hit, is_self, sel;

    always_comb begin
        phys_hit  = (dest == BCAST_DEST) || (dest == MY_IDX);
        flat_hit  = (model == MODEL_FLAT) && ((dest & log_id) != 8'h00);
        clus_hit  = (model == MODEL_CLUSTER) && (dest[7:4] == log_id[7:4])
                    && ((dest[3:0] & log_id[3:0]) != 4'h0);
        field_hit = logical ? (flat_hit | clus_hit) : phys_hit;
        is_self   = (src_id == MY_IDX);
        case (shorthand)
            SH_FIELD:  sel = field_hit;
            SH_SELF:   sel = is_self;
            SH_ALL:    sel = 1'b1;
            default:   sel = !is_self;
        endcase
        hit = present & sel;
    end
endmodule

// File: rtl/irq_lowest_keep.sv
module irq_lowest_keep #(
    parameter int N = 8
) (
    input  logic [N-1:0] in_mask,
    output logic [N-1:0] out_mask
);
    // Isolate the least significant set bit (two's-complement trick).
    always_comb begin
        out_mask = in_mask & (~in_mask + N'(1));
    end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_res_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [7:0]     req_dest,
    input  logic           req_logical,
    input  logic [1:0]     req_shorthand,
    input  logic [7:0]     req_src_id,
    input  logic [2:0]     req_dmode,
    input  logic [N-1:0]   unit_present,
    input  logic [8*N-1:0] unit_log_id,
    input  logic [4*N-1:0] unit_model,
    output logic [N-1:0]   tgt_mask,
    output logic           tgt_valid
);
    typedef struct packed {
        logic         valid;
        logic [N-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    logic [N-1:0] raw_hits;
    logic [N-1:0] lowest_hit;

    for (genvar i = 0; i < N; i++) begin : g_unit
        irq_unit_match #(.UNIT_IDX(i)) u_match (
            .dest      (req_dest),
            .logical   (req_logical),
            .shorthand (req_shorthand),
            .src_id    (req_src_id),
            .log_id    (unit_log_id[8*i +: 8]),
            .model     (unit_model[4*i +: 4]),
            .present   (unit_present[i]),
            .hit       (raw_hits[i])
        );
    end

    irq_lowest_keep #(.N(N)) u_lowest (
        .in_mask  (raw_hits),
        .out_mask (lowest_hit)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        if (req_valid) begin
            state_d.mask = (req_dmode == DM_LOWEST) ? lowest_hit : raw_hits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tgt_mask  = state_q.mask;
    assign tgt_valid = state_q.valid;

    // R2: strobe follows a request by exactly one cycle
    a_r2_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> tgt_valid);
    a_r2_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !tgt_valid);
    a_r2_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(tgt_mask));
    // R8: absent units never appear in the result
    a_r8_absent_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((tgt_mask & ~$past(unit_present)) == '0));
    // R9: lowest-priority result has at most one target
    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dmode == 3'd1) |=> $onehot0(tgt_mask));
    // R3: self shorthand selects at most one target
    a_r3_self_single: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_shorthand == 2'd1) |=> ($countones(tgt_mask) <= 1));
endmodule

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [7:0]     req_dest = '0;
    logic           req_logical = 1'b0;
    logic [1:0]     req_shorthand = '0;
    logic [7:0]     req_src_id = '0;
    logic [2:0]     req_dmode = '0;
    logic [N-1:0]   unit_present = '1;
    logic [8*N-1:0] unit_log_id = '0;
    logic [4*N-1:0] unit_model = '0;
    logic [N-1:0]   tgt_mask;
    logic           tgt_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_dest_resolver #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_shorthand(req_shorthand),
        .req_src_id(req_src_id), .req_dmode(req_dmode),
        .unit_present(unit_present), .unit_log_id(unit_log_id),
        .unit_model(unit_model), .tgt_mask(tgt_mask), .tgt_valid(tgt_valid)
    );

    function automatic logic [N-1:0] expect_mask(
        input logic [7:0] d, input logic lg, input logic [1:0] sh,
        input logic [7:0] src, input logic [2:0] dm);
        logic [N-1:0] m;
        logic [N-1:0] one;
        m = '0;
        for (int i = 0; i < N; i++) begin
            logic [7:0] id;
            logic [3:0] md;
            id = unit_log_id[8*i +: 8];
            md = unit_model[4*i +: 4];
            case (sh)
                2'd0: begin
                    if (!lg) m[i] = (d == 8'hFF) || (int'(d) == i);
                    else if (md == 4'hF) m[i] = (d & id) != 0;
                    else if (md == 4'h0) m[i] = (d[7:4] == id[7:4]) && ((d[3:0] & id[3:0]) != 0);
                    else m[i] = 1'b0;
                end
                2'd1: m[i] = (int'(src) == i);
                2'd2: m[i] = 1'b1;
                default: m[i] = (int'(src) != i);
            endcase
        end
        m = m & unit_present;
        if (dm == 3'd1) begin
            one = '0;
            for (int i = N - 1; i >= 0; i--) if (m[i]) one = '0 | (N'(1) << i);
            m = one;
        end
        return m;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic run_req(input string tag, input logic [7:0] d, input logic lg,
                           input logic [1:0] sh, input logic [7:0] src, input logic [2:0] dm);
        logic [N-1:0] exp;
        exp = expect_mask(d, lg, sh, src, dm);
        req_dest = d; req_logical = lg; req_shorthand = sh;
        req_src_id = src; req_dmode = dm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_dest = ~d; req_logical = ~lg;   // idle changes must not disturb the result
        check("R2 strobe", N'(tgt_valid), N'(1));
        check(tag, tgt_mask, exp);
        @(negedge clk);
        check("R2 hold", {tgt_mask[N-2:0], tgt_valid}, {exp[N-2:0], 1'b0});
    endtask

    task automatic set_cfg(input int c);
        for (int i = 0; i < N; i++) begin
            case (c)
                0: begin
                    unit_model[4*i +: 4] = (i % 3 == 0) ? 4'hF : (i % 3 == 1) ? 4'h0 : 4'h5;
                    unit_log_id[8*i +: 8] = 8'((i * 37 + 11) & 255);
                end
                1: begin
                    unit_model[4*i +: 4] = 4'hF;
                    unit_log_id[8*i +: 8] = 8'(1 << i);
                end
                default: begin
                    unit_model[4*i +: 4] = 4'h0;
                    unit_log_id[8*i +: 8] = {4'(i / 4), 4'(1 << (i % 4))};
                end
            endcase
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        set_cfg(0);
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 reset mask", tgt_mask, '0);
        check("R1 reset valid", N'(tgt_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {tgt_mask[N-2:0], tgt_valid}, '0);

        // Destination sweep: R4 physical, R5 R6 R7 logical, R8 presence, R9 lowest priority
        for (int c = 0; c < 3; c++) begin
            set_cfg(c);
            for (int p = 0; p < 2; p++) begin
                unit_present = (p == 0) ? '1 : N'(8'b1011_0110);
                for (int lg = 0; lg < 2; lg++)
                    for (int dm = 0; dm < 2; dm++)
                        for (int d = 0; d < 256; d++)
                            run_req(lg != 0 ? (p != 0 ? "R5 R6 R7 R8" : "R5 R6 R7")
                                            : (p != 0 ? "R4 R8" : "R4"),
                                    8'(d), lg[0], 2'd0, 8'h00, dm != 0 ? 3'd1 : 3'd0);
            end
        end

        // Shorthand sweep: R3, destination and mode ignored for R10
        set_cfg(0);
        for (int p = 0; p < 2; p++) begin
            unit_present = (p == 0) ? '1 : N'(8'b0110_1101);
            for (int sh = 1; sh < 4; sh++)
                for (int s = 0; s < 10; s++)
                    for (int v = 0; v < 4; v++)
                        run_req("R3 R10", 8'((s * 53 + v * 91) & 255), v[0], 2'(sh), 8'(s), 3'd0);
        end

        // Delivery code sweep: R9
        unit_present = N'(8'b1110_1000);
        for (int dm = 0; dm < 8; dm++) begin
            run_req("R9 all", 8'h00, 1'b0, 2'd2, 8'h03, 3'(dm));
            run_req("R9 others", 8'h00, 1'b0, 2'd3, 8'h03, 3'(dm));
            run_req("R9 bcast", 8'hFF, 1'b0, 2'd0, 8'h00, 3'(dm));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule